// File: doc/BRIEF.md
# Modular Exponentiation Engine (MSB-first square-and-multiply)

This block raises a message value to a power modulo an odd modulus, returning result = msg^exponent mod modulus. It is the arithmetic core of a public-key cipher. Encryption and decryption use the same circuit, and only the exponent applied at start differs. The exponent is walked from its top bit to bit 0. Every bit after the top one costs a squaring of the running value, and each 1 bit adds one multiplication by the message after that squaring.

All arithmetic runs on one shared bit-serial Montgomery multiplier with R = 2^WIDTH. The caller supplies R^2 mod modulus with each request. The engine uses it to map the message, and the value one, into the Montgomery domain. A final multiplication by one maps the result back out. A request is accepted when start is high while ready is high. The operands are captured at that edge. Ready stays low until the result is on the output.

Top module: `modexp_engine`

## Requirements
- R1: After reset, ready is 1 and result is 0.
- R2: For an odd modulus n > 1, msg < n and r2_mod = 2^(2*WIDTH) mod n, the result presented when ready returns is msg^exponent mod n. The exponent is read as an unsigned EXP_W-bit number, and every internal Montgomery product is below n.
- R3: An all-zero exponent yields result 1.
- R4: An exponent of 1 yields msg. An exponent with only its top bit set yields msg^(2^(EXP_W-1)) mod n.
- R5: Running msg through a public exponent and then running the output through the matching private exponent, on the same engine, returns the original msg.
- R6: Ready is low in the cycle after an accepted start and stays low until the result is valid. The shared multiplier is only launched while it is idle, and for one cycle at a time.
- R7: While a request is running, start and changes to msg, exponent, modulus and r2_mod have no effect on that request's result. While the engine is idle and start is low, result holds its value.
- R8: An all-ones exponent, which needs the largest number of multiplications, still gives msg^exponent mod n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken while ready is high |
| msg | input | WIDTH | Base value, below the modulus |
| exponent | input | EXP_W | Exponent, scanned from its top bit |
| modulus | input | WIDTH | Odd modulus |
| r2_mod | input | WIDTH | 2^(2*WIDTH) mod modulus |
| ready | output | 1 | High when idle and able to take a request |
| result | output | WIDTH | Last computed value |

## Verification
The checker watches the handshake on every cycle. It confirms that ready falls after an accepted start, that the multiplier is launched only while idle and only for one cycle, that every multiplier product is reduced below the modulus, and that the result holds while idle. The arithmetic itself cannot be seen from one cycle to the next. Only the bench's scenarios show that the square-and-multiply schedule, the domain conversions and the corner exponents (zero, one, top bit only, all ones) produce the right value, and that an encrypt-then-decrypt pair returns the message. The same scenarios show that operands changed in mid-run are ignored.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_SQUARE,
        ST_MULTIPLY,
        ST_NEXT_BIT,
        ST_FINAL,
        ST_DONE
    } mx_state_e;

    typedef enum logic [2:0] {
        OP_TO_MONT_M,
        OP_TO_MONT_ONE,
        OP_SQUARE,
        OP_MULT,
        OP_FROM_MONT
    } mm_op_e;

endpackage

// File: rtl/mont_mul.sv
module mont_mul #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] n,
    output logic             ready,
    output logic [WIDTH-1:0] p
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam int ACC_W = WIDTH + 2;

    typedef struct packed {
        logic             busy;
        logic             fin;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] a_sh;
        logic [WIDTH-1:0] b;
        logic [WIDTH-1:0] n;
        logic [ACC_W-1:0] s;
        logic [WIDTH-1:0] p;
    } mm_regs_t;

    mm_regs_t r_q, r_d;
    logic [ACC_W-1:0] sum_a, sum_n;

    // one radix-2 step: add b when the scanned bit of a is set, make even with n
    always_comb begin
        sum_a = r_q.s + (r_q.a_sh[0] ? {2'b00, r_q.b} : '0);
        sum_n = sum_a + (sum_a[0] ? {2'b00, r_q.n} : '0);
    end

    always_comb begin
        r_d = r_q;
        if (start && !r_q.busy && !r_q.fin) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.a_sh = a;
            r_d.b    = b;
            r_d.n    = n;
            r_d.s    = '0;
        end else if (r_q.busy) begin
            r_d.s    = sum_n >> 1;
            r_d.a_sh = r_q.a_sh >> 1;
            r_d.cnt  = r_q.cnt + 1'b1;
            if (r_q.cnt == CNT_W'(WIDTH - 1)) begin
                r_d.busy = 1'b0;
                r_d.fin  = 1'b1;
            end
        end else if (r_q.fin) begin
            r_d.fin = 1'b0;
            if (r_q.s >= {2'b00, r_q.n}) r_d.p = WIDTH'(r_q.s - {2'b00, r_q.n});
            else                         r_d.p = WIDTH'(r_q.s);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready = !r_q.busy && !r_q.fin;
    assign p     = r_q.p;

endmodule

// File: rtl/mm_operand_sel.sv
module mm_operand_sel
    import modexp_pkg::*;
#(
    parameter int WIDTH = 128
) (
    input  mm_op_e           op,
    input  logic [WIDTH-1:0] msg,
    input  logic [WIDTH-1:0] r2,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mbar,
    output logic [WIDTH-1:0] a,
    output logic [WIDTH-1:0] b
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        a = acc;
        b = acc;
        unique case (op)
            OP_TO_MONT_M:   begin a = msg; b = r2;   end
            OP_TO_MONT_ONE: begin a = ONE; b = r2;   end
            OP_SQUARE:      begin a = acc; b = acc;  end
            OP_MULT:        begin a = acc; b = mbar; end
            OP_FROM_MONT:   begin a = acc; b = ONE;  end
            default:        begin a = acc; b = acc;  end
        endcase
    end

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
    import modexp_pkg::*;
#(
    parameter int WIDTH = 128,
    parameter int EXP_W = WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] msg,
    input  logic [EXP_W-1:0] exponent,
    input  logic [WIDTH-1:0] modulus,
    input  logic [WIDTH-1:0] r2_mod,
    output logic             ready,
    output logic [WIDTH-1:0] result
);
    localparam int IDX_W = (EXP_W > 2) ? $clog2(EXP_W) : 1;

    typedef struct packed {
        mx_state_e        state;
        logic             conv_one;
        logic             issued;
        logic [IDX_W-1:0] idx;
        logic [WIDTH-1:0] m;
        logic [WIDTH-1:0] n;
        logic [WIDTH-1:0] r2;
        logic [WIDTH-1:0] mbar;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] res;
        logic [EXP_W-1:0] e;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    mm_op_e           mul_op;
    logic             mul_start;
    logic             mul_ready;
    logic             mul_done;
    logic [WIDTH-1:0] mul_a, mul_b, mul_p;
    logic [WIDTH-1:0] mod_held;

    assign mod_held = r_q.n;
    assign mul_done = r_q.issued && mul_ready;

    mm_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .op   (mul_op),
        .msg  (r_q.m),
        .r2   (r_q.r2),
        .acc  (r_q.acc),
        .mbar (r_q.mbar),
        .a    (mul_a),
        .b    (mul_b)
    );

    mont_mul #(.WIDTH(WIDTH)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (mul_a),
        .b     (mul_b),
        .n     (r_q.n),
        .ready (mul_ready),
        .p     (mul_p)
    );

    always_comb begin
        r_d       = r_q;
        mul_op    = OP_SQUARE;
        mul_start = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.m        = msg;
                    r_d.e        = exponent;
                    r_d.n        = modulus;
                    r_d.r2       = r2_mod;
                    r_d.conv_one = 1'b0;
                    r_d.issued   = 1'b0;
                    r_d.idx      = IDX_W'(EXP_W - 1);
                    r_d.state    = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                mul_op = r_q.conv_one ? OP_TO_MONT_ONE : OP_TO_MONT_M;
                if (!r_q.issued) begin
                    mul_start  = 1'b1;
                    r_d.issued = 1'b1;
                end else if (mul_done) begin
                    r_d.issued = 1'b0;
                    if (!r_q.conv_one) begin
                        r_d.mbar     = mul_p;
                        r_d.conv_one = 1'b1;
                    end else begin
                        // seed from the top exponent bit
                        r_d.acc   = r_q.e[EXP_W-1] ? r_q.mbar : mul_p;
                        r_d.state = ST_NEXT_BIT;
                    end
                end
            end
            ST_NEXT_BIT: begin
                if (r_q.idx == '0) begin
                    r_d.state = ST_FINAL;
                end else begin
                    r_d.idx   = r_q.idx - 1'b1;
                    r_d.state = ST_SQUARE;
                end
            end
            ST_SQUARE: begin
                mul_op = OP_SQUARE;
                if (!r_q.issued) begin
                    mul_start  = 1'b1;
                    r_d.issued = 1'b1;
                end else if (mul_done) begin
                    r_d.issued = 1'b0;
                    r_d.acc    = mul_p;
                    r_d.state  = r_q.e[r_q.idx] ? ST_MULTIPLY : ST_NEXT_BIT;
                end
            end
            ST_MULTIPLY: begin
                mul_op = OP_MULT;
                if (!r_q.issued) begin
                    mul_start  = 1'b1;
                    r_d.issued = 1'b1;
                end else if (mul_done) begin
                    r_d.issued = 1'b0;
                    r_d.acc    = mul_p;
                    r_d.state  = ST_NEXT_BIT;
                end
            end
            ST_FINAL: begin
                mul_op = OP_FROM_MONT;
                if (!r_q.issued) begin
                    mul_start  = 1'b1;
                    r_d.issued = 1'b1;
                end else if (mul_done) begin
                    r_d.issued = 1'b0;
                    r_d.res    = mul_p;
                    r_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready  = (r_q.state == ST_IDLE);
    assign result = r_q.res;

endmodule

// File: rtl/modexp_engine_chk.sv
module modexp_engine_chk #(
    parameter int WIDTH = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ready,
    input logic [WIDTH-1:0] result,
    input logic             mul_start,
    input logic             mul_ready,
    input logic [WIDTH-1:0] mul_p,
    input logic [WIDTH-1:0] mod_held
);

    // R6: an accepted request takes the engine out of idle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ready && start |=> !ready);

    // R6: multiplier launched only while it is idle
    a_r6_launch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> mul_ready);

    // R6: each launch is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |=> !mul_start);

    // R2: every finished Montgomery product is fully reduced
    a_r2_product_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mul_ready) |-> (mul_p < mod_held));

    // R7: result holds while idle without a request
    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !start |=> $stable(result));

endmodule

bind modexp_engine modexp_engine_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .result    (result),
    .mul_start (mul_start),
    .mul_ready (mul_ready),
    .mul_p     (mul_p),
    .mod_held  (mod_held)
);

// File: tb/modexp_engine_test.sv
module modexp_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int E = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] msg = '0;
    logic [E-1:0] exponent = '0;
    logic [W-1:0] modulus = '0;
    logic [W-1:0] r2_mod = '0;
    logic         ready;
    logic [W-1:0] result;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;
    logic prev_ready = 1'b1;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    modexp_engine #(.WIDTH(W), .EXP_W(E)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg(msg),
        .exponent(exponent), .modulus(modulus), .r2_mod(r2_mod),
        .ready(ready), .result(result)
    );

    function automatic logic [W-1:0] ref_pow(longint unsigned m, longint unsigned e,
                                             longint unsigned n);
        longint unsigned r = 1 % n;
        longint unsigned b = m % n;
        for (int i = 0; i < E; i++) begin
            if ((e >> i) & 1) r = (r * b) % n;
            b = (b * b) % n;
        end
        return W'(r);
    endfunction

    function automatic logic [W-1:0] r2_of(longint unsigned n);
        return W'((64'd1 << (2*W)) % n);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // driver: push expectation, launch, optionally disturb, wait for ready
    task automatic run(logic [W-1:0] m, logic [E-1:0] e, logic [W-1:0] n,
                       logic [W-1:0] expv, string tag, bit disturb);
        @(negedge clk);
        msg = m; exponent = e; modulus = n; r2_mod = r2_of(n);
        start = 1'b1;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        check("R6 ready low after start", W'(ready), W'(0));
        if (disturb) begin
            repeat (3) @(negedge clk);
            msg = ~m; exponent = ~e; modulus = 16'd9; r2_mod = 16'd7;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (ready !== 1'b1) @(negedge clk);
    endtask

    // monitor: compare on each return of ready
    always @(negedge clk) begin
        if (rst_n) begin
            if (ready === 1'b1 && prev_ready === 1'b0) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected completion", result, result ^ 16'h1);
                end else begin
                    check(tag_q.pop_front(), result, exp_q.pop_front());
                end
            end
            prev_ready = ready;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1 ready after reset", W'(ready), W'(1));
        check("R1 result after reset", result, W'(0));
        rst_n = 1'b1;

        run(16'd5, 16'd3, 16'd23, ref_pow(5, 3, 23), "R2 small", 0);
        run(16'd3, 16'd21, 16'd9999, ref_pow(3, 21, 9999), "R2 exponent 10101", 0);
        run(16'd1234, 16'hBEEF, 16'd40961, ref_pow(1234, 16'hBEEF, 40961), "R2 mixed", 0);
        run(16'd7, 16'hA5A5, 16'd65521, ref_pow(7, 16'hA5A5, 65521), "R2 large n", 0);
        run(16'd0, 16'd5, 16'd17, 16'd0, "R2 zero base", 0);
        run(16'd100, 16'd2, 16'd101, 16'd1, "R2 base n-1", 0);
        run(16'd55, 16'd0, 16'd77, 16'd1, "R3 zero exponent", 0);
        run(16'd42, 16'd1, 16'd101, 16'd42, "R4 exponent one", 0);
        run(16'd3, 16'h8000, 16'd65519, ref_pow(3, 16'h8000, 65519), "R4 top bit only", 0);
        run(16'd65, 16'd17, 16'd3233, 16'd2790, "R5 encrypt", 0);
        run(16'd2790, 16'd2753, 16'd3233, 16'd65, "R5 decrypt", 0);
        run(16'd2, 16'hFFFF, 16'd65533, ref_pow(2, 16'hFFFF, 65533), "R8 all ones", 0);
        run(16'd321, 16'h1357, 16'd4999, ref_pow(321, 16'h1357, 4999), "R7 disturbed run", 1);

        // R7: idle with changing inputs and no start keeps the result
        @(negedge clk);
        held = result;
        msg = 16'd11; exponent = 16'd3; modulus = 16'd13; r2_mod = 16'd1;
        repeat (5) @(negedge clk);
        check("R7 idle hold", result, held);
        check("R7 still idle", W'(ready), W'(1));

        repeat (2) @(negedge clk);
        check("R6 scoreboard drained", W'(exp_q.size()), W'(0));
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule